// File: doc/BRIEF.md
# Scanline Timing and Display Status

This block derives line and frame timing for a display from a dot-cycle clock enable. A horizontal counter runs through the drawing part of each line and then the horizontal blanking part. A 9-bit line counter steps once per line and wraps after the last line of the frame. Both counters are decoded into vertical-blank and horizontal-blank status flags.

Two processors share the block. Each has its own copy of the display status register, which holds three interrupt enables and a 9-bit line-compare value. Each processor receives its own vertical-blank and line-compare interrupt pulses. A single strobe marks the start of horizontal blanking on visible lines and is meant to trigger DMA. Registers are byte-wide and sit behind a plain write strobe with combinational read data. A port-select input picks which processor's status copy a register access reaches.

All timing figures are parameters. The defaults are 1536 drawing cycles, 594 blanking cycles, a 70-cycle lag on the readable hblank flag, 192 visible lines and 263 lines per frame.

Top module: `disp_line_timer`

## Requirements
- R1: The horizontal counter advances only on clocks where `dot_en` is 1. A line lasts DRAW_CYC + BLANK_CYC (default 2130) dot-enabled cycles, and the line counter advances on the enabled edge that ends a line.
- R2: The line counter runs from 0 to TOTAL_LINES-1 (default 262) and then returns to 0. Address 2 reads its bits 7:0. Address 3 reads its bit 8 in data bit 0, with data bits 7:1 reading 0.
- R3: `vblank`, and bit 0 of the status low byte (address 0), are 1 exactly when the line counter lies between VIS_LINES and TOTAL_LINES-2, inclusive (default 192..261). They are 0 on the last line.
- R4: `hblank`, and status bit 1, are 1 exactly when the horizontal count is at least DRAW_CYC + HFLAG_LAG (default 1606).
- R5: Status low byte (address 0) layout: bit 2 is this port's match flag; bit 3 is the vblank interrupt enable; bit 4 is the hblank enable, which is stored only; bit 5 is the compare interrupt enable; bit 6 reads 0; bit 7 is compare bit 8. Address 1 reads and writes compare bits 7:0.
- R6: A write to address 0 changes only bits 3, 4, 5 and 7; written bits 0..2 have no effect. Writes to addresses 2 and 3 have no effect.
- R7: When the line counter advances to VIS_LINES, each port whose vblank enable is set receives a one-clock pulse on its `irq_vblank` bit.
- R8: Each time the line counter changes, each port's match flag is reloaded with (new line == compare value). If that port's compare enable is set and the flag is 1, the port receives a one-clock `irq_vmatch` pulse. A compare write between line changes does not alter the flag.
- R9: `hblank_dma` pulses for one clock when the horizontal count reaches DRAW_CYC, on lines below VIS_LINES only.
- R10: The two status copies are independent: an access with `reg_port` = p reads or changes only copy p, and each copy drives only its own interrupt bits.
- R11: After reset, both counters, all enables, both compare values and both match flags are 0, and no pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot-cycle enable; counters step when high |
| reg_port | input | 1 | Processor select for register access |
| reg_addr | input | 2 | 0 status low, 1 compare low, 2 line low, 3 line high |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_port/reg_addr |
| vblank | output | 1 | Vertical blank flag |
| hblank | output | 1 | Horizontal blank flag (lagged) |
| hblank_dma | output | 1 | One-clock strobe at start of hblank on visible lines |
| irq_vblank | output | 2 | Per-port vblank interrupt pulse |
| irq_vmatch | output | 2 | Per-port line-compare interrupt pulse |

## Verification
`vblank`, `hblank` and the status flags depend on the counters' state. They change in the first clock after the dot-enabled edge that moves the counters. The interrupt pulses and `hblank_dma` come from registers loaded on that same edge, so they are high during exactly that one following clock. A register write is visible on `reg_rdata` in the clock after its write edge, while a read needs no clock. The bench drives all inputs just after the falling edge. At the next falling edge it compares every output against its behavioural model, which it advances with the inputs the rising edge in between has just consumed. Small timing parameters make whole frames, including the wrap and the blank lines, run many times.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int LINE_W = 9;

  localparam logic [1:0] A_STAT_LO = 2'd0;
  localparam logic [1:0] A_CMP_LO  = 2'd1;
  localparam logic [1:0] A_LINE_LO = 2'd2;
  localparam logic [1:0] A_LINE_HI = 2'd3;

  // One processor's status copy
  typedef struct packed {
    logic              vbl_en;
    logic              hbl_en;
    logic              cmp_en;
    logic [LINE_W-1:0] cmp;
  } stat_cfg_t;
endpackage

// File: rtl/dlt_counters.sv
module dlt_counters #(
  parameter int DRAW_CYC    = 1536,
  parameter int BLANK_CYC   = 594,
  parameter int HFLAG_LAG   = 70,
  parameter int VIS_LINES   = 192,
  parameter int TOTAL_LINES = 263
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       dot_en,
  output logic [dlt_pkg::LINE_W-1:0] vcnt_o,
  output logic [dlt_pkg::LINE_W-1:0] vnext_o,
  output logic                       line_adv_o,
  output logic                       vblank_o,
  output logic                       hblank_o,
  output logic                       hbl_dma_o
);
  localparam int LINE_CYC = DRAW_CYC + BLANK_CYC;
  localparam int HW       = $clog2(LINE_CYC);
  localparam int VW       = dlt_pkg::LINE_W;
  localparam logic [HW-1:0] H_LAST  = HW'(LINE_CYC - 1);
  localparam logic [HW-1:0] H_PRE   = HW'(DRAW_CYC - 1);
  localparam logic [HW-1:0] H_DRAW  = HW'(DRAW_CYC);
  localparam logic [HW-1:0] H_FLAG  = HW'(DRAW_CYC + HFLAG_LAG);
  localparam logic [VW-1:0] V_LAST  = VW'(TOTAL_LINES - 1);
  localparam logic [VW-1:0] V_VIS   = VW'(VIS_LINES);
  localparam logic [VW-1:0] V_VBEND = VW'(TOTAL_LINES - 2);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          at_end;
  logic [VW-1:0] vnext;
  logic          dma_q;

  always_comb begin
    at_end = dot_en && (hcnt == H_LAST);
    vnext  = (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      dma_q <= 1'b0;
    end else begin
      dma_q <= dot_en && (hcnt == H_PRE) && (vcnt < V_VIS);
      if (dot_en) begin
        hcnt <= at_end ? '0 : hcnt + HW'(1);
        if (at_end) vcnt <= vnext;
      end
    end
  end

  assign vcnt_o     = vcnt;
  assign vnext_o    = vnext;
  assign line_adv_o = at_end;
  assign vblank_o   = (vcnt >= V_VIS) && (vcnt <= V_VBEND);
  assign hblank_o   = (hcnt >= H_FLAG);
  assign hbl_dma_o  = dma_q;

  a_r1_h_range: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= H_LAST);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> ($stable(hcnt) && $stable(vcnt)));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && hcnt == H_LAST && vcnt == V_LAST) |=> (vcnt == '0));
  a_r2_v_range: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= V_LAST);
  a_r9_dma_place: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> (hcnt == H_DRAW && vcnt < V_VIS));
  a_r9_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |=> !dma_q);
endmodule

// File: rtl/dlt_status_port.sv
module dlt_status_port #(
  parameter int VIS_LINES = 192
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_adv,
  input  logic [dlt_pkg::LINE_W-1:0] vcnt,
  input  logic [dlt_pkg::LINE_W-1:0] vnext,
  input  logic                       wr_lo,
  input  logic                       wr_cmp,
  input  logic [7:0]                 wdata,
  output dlt_pkg::stat_cfg_t         cfg_o,
  output logic                       match_o,
  output logic                       irq_vbl_o,
  output logic                       irq_cmp_o
);
  localparam int VW = dlt_pkg::LINE_W;
  localparam logic [VW-1:0] V_VIS = VW'(VIS_LINES);

  dlt_pkg::stat_cfg_t cfg;
  logic match_q, irq_vbl_q, irq_cmp_q;
  logic hit_next;

  assign hit_next = (vnext == cfg.cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      match_q   <= 1'b0;
      irq_vbl_q <= 1'b0;
      irq_cmp_q <= 1'b0;
    end else begin
      irq_vbl_q <= line_adv && (vnext == V_VIS) && cfg.vbl_en;
      irq_cmp_q <= line_adv && hit_next && cfg.cmp_en;
      if (line_adv) match_q <= hit_next;
      if (wr_lo) begin
        cfg.vbl_en    <= wdata[3];
        cfg.hbl_en    <= wdata[4];
        cfg.cmp_en    <= wdata[5];
        cfg.cmp[VW-1] <= wdata[7];
      end
      if (wr_cmp) cfg.cmp[7:0] <= wdata;
    end
  end

  assign cfg_o     = cfg;
  assign match_o   = match_q;
  assign irq_vbl_o = irq_vbl_q;
  assign irq_cmp_o = irq_cmp_q;

  a_r8_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_adv |=> $stable(match_q));
  a_r8_irq_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_q |-> match_q);
  a_r7_vbl_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vbl_q |-> (vcnt == V_VIS));
  a_r11_pulse_vbl: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vbl_q |=> !irq_vbl_q);
  a_r11_pulse_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp_q |=> !irq_cmp_q);
  a_r6_lo_keeps_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_cmp) |=> $stable(cfg.cmp[7:0]));
endmodule

// File: rtl/disp_line_timer.sv
module disp_line_timer #(
  parameter int DRAW_CYC    = 1536,
  parameter int BLANK_CYC   = 594,
  parameter int HFLAG_LAG   = 70,
  parameter int VIS_LINES   = 192,
  parameter int TOTAL_LINES = 263,
  parameter int NUM_PORTS   = 2,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dot_en,
  input  logic [PW-1:0]        reg_port,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 vblank,
  output logic                 hblank,
  output logic                 hblank_dma,
  output logic [NUM_PORTS-1:0] irq_vblank,
  output logic [NUM_PORTS-1:0] irq_vmatch
);
  import dlt_pkg::*;
  localparam int VW = LINE_W;

  logic [VW-1:0] vcnt, vnext;
  logic          line_adv;
  stat_cfg_t     cfg_a [NUM_PORTS];
  logic [NUM_PORTS-1:0] match_a;

  dlt_counters #(
    .DRAW_CYC(DRAW_CYC), .BLANK_CYC(BLANK_CYC), .HFLAG_LAG(HFLAG_LAG),
    .VIS_LINES(VIS_LINES), .TOTAL_LINES(TOTAL_LINES)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en),
    .vcnt_o(vcnt), .vnext_o(vnext), .line_adv_o(line_adv),
    .vblank_o(vblank), .hblank_o(hblank), .hbl_dma_o(hblank_dma)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic sel;
    assign sel = reg_wr && (reg_port == PW'(g));
    dlt_status_port #(.VIS_LINES(VIS_LINES)) u_stat (
      .clk(clk), .rst_n(rst_n), .line_adv(line_adv),
      .vcnt(vcnt), .vnext(vnext),
      .wr_lo(sel && reg_addr == A_STAT_LO),
      .wr_cmp(sel && reg_addr == A_CMP_LO),
      .wdata(reg_wdata),
      .cfg_o(cfg_a[g]), .match_o(match_a[g]),
      .irq_vbl_o(irq_vblank[g]), .irq_cmp_o(irq_vmatch[g])
    );
  end

  stat_cfg_t cfg_s;
  logic      match_s;

  always_comb begin
    cfg_s   = '0;
    match_s = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reg_port == PW'(p)) begin
        cfg_s   = cfg_a[p];
        match_s = match_a[p];
      end
    end
    case (reg_addr)
      A_STAT_LO: reg_rdata = {cfg_s.cmp[VW-1], 1'b0, cfg_s.cmp_en, cfg_s.hbl_en,
                              cfg_s.vbl_en, match_s, hblank, vblank};
      A_CMP_LO:  reg_rdata = cfg_s.cmp[7:0];
      A_LINE_LO: reg_rdata = vcnt[7:0];
      default:   reg_rdata = {7'b0, vcnt[VW-1]};
    endcase
  end

  a_r7_vbl_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_vblank) |-> vblank);
  a_r9_dma_not_vblank: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_dma |-> !vblank);
  a_r6_line_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[1] && !line_adv) |=> $stable(vcnt));
endmodule

// File: tb/sim_disp_line_timer.sv
`timescale 1ns/1ps
module sim_disp_line_timer;
  localparam int DRAW = 20, BLANK = 10, LAG = 4, VIS = 5, TOT = 8;
  localparam int LINE = DRAW + BLANK;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, dot_en, reg_port, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic vblank, hblank, hblank_dma;
  logic [1:0] irq_vblank, irq_vmatch;

  disp_line_timer #(.DRAW_CYC(DRAW), .BLANK_CYC(BLANK), .HFLAG_LAG(LAG),
                    .VIS_LINES(VIS), .TOTAL_LINES(TOT), .NUM_PORTS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_port(reg_port),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vblank(vblank), .hblank(hblank),
    .hblank_dma(hblank_dma), .irq_vblank(irq_vblank), .irq_vmatch(irq_vmatch));

  // reference state
  int mh, mv, m_dma;
  int m_vbe[2], m_hbe[2], m_cme[2], m_cmp[2], m_match[2], m_ivb[2], m_ivm[2];
  int errors = 0, checks = 0, cyc = 0, dot_mode = 0, rot = 0;
  bit done = 0;
  bit st_wr = 0, st_port = 0;
  int st_addr = 0, st_data = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (line %0d dot %0d)", what, act, exp, mv, mh);
    end
  endtask

  task automatic check_all();
    int ev, eh, p, er;
    ev = (mv >= VIS && mv <= TOT - 2) ? 1 : 0;
    eh = (mh >= DRAW + LAG) ? 1 : 0;
    chk(vblank == ev, "R3 vblank", vblank, ev);
    chk(hblank == eh, "R1 R4 hblank", hblank, eh);
    chk(hblank_dma == m_dma, "R9 hblank_dma", hblank_dma, m_dma);
    chk(irq_vblank == 2'((m_ivb[1] << 1) | m_ivb[0]), "R7 R10 irq_vblank",
        irq_vblank, (m_ivb[1] << 1) | m_ivb[0]);
    chk(irq_vmatch == 2'((m_ivm[1] << 1) | m_ivm[0]), "R8 R10 irq_vmatch",
        irq_vmatch, (m_ivm[1] << 1) | m_ivm[0]);
    p = reg_port;
    case (reg_addr)
      2'd0: begin
        er = (((m_cmp[p] >> 8) & 1) << 7) | (m_cme[p] << 5) | (m_hbe[p] << 4) |
             (m_vbe[p] << 3) | (m_match[p] << 2) | (eh << 1) | ev;
        chk(reg_rdata == 8'(er), "R5 R6 R10 status low", reg_rdata, er);
      end
      2'd1: chk(reg_rdata == 8'(m_cmp[p]), "R5 R10 compare low", reg_rdata, m_cmp[p] & 255);
      2'd2: chk(reg_rdata == 8'(mv), "R2 R6 line low", reg_rdata, mv & 255);
      default: chk(reg_rdata == 8'(mv >> 8), "R2 R6 line high", reg_rdata, mv >> 8);
    endcase
  endtask

  task automatic model_reset();
    mh = 0; mv = 0; m_dma = 0;
    for (int p = 0; p < 2; p++) begin
      m_vbe[p] = 0; m_hbe[p] = 0; m_cme[p] = 0; m_cmp[p] = 0;
      m_match[p] = 0; m_ivb[p] = 0; m_ivm[p] = 0;
    end
  endtask

  task automatic model_adv();
    int ovbe[2], ocme[2], ocmp[2];
    for (int p = 0; p < 2; p++) begin
      ovbe[p] = m_vbe[p]; ocme[p] = m_cme[p]; ocmp[p] = m_cmp[p];
      m_ivb[p] = 0; m_ivm[p] = 0;
    end
    m_dma = (dot_en && mh == DRAW - 1 && mv < VIS) ? 1 : 0;
    if (reg_wr) begin
      if (reg_addr == 2'd0) begin
        m_vbe[reg_port] = reg_wdata[3];
        m_hbe[reg_port] = reg_wdata[4];
        m_cme[reg_port] = reg_wdata[5];
        m_cmp[reg_port] = (m_cmp[reg_port] & 255) | (reg_wdata[7] << 8);
      end else if (reg_addr == 2'd1) begin
        m_cmp[reg_port] = (m_cmp[reg_port] & 256) | reg_wdata;
      end
    end
    if (dot_en) begin
      if (mh == LINE - 1) begin
        mh = 0;
        mv = (mv == TOT - 1) ? 0 : mv + 1;
        for (int p = 0; p < 2; p++) begin
          m_match[p] = (mv == ocmp[p]) ? 1 : 0;
          m_ivm[p] = m_match[p] & ocme[p];
          m_ivb[p] = (mv == VIS) ? ovbe[p] : 0;
        end
      end else mh++;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    check_all();
    dot_en    = (dot_mode == 0) ? 1'b1 : ((cyc % 4) != 3);
    reg_wr    = st_wr;
    reg_port  = st_port;
    reg_addr  = 2'(st_addr);
    reg_wdata = 8'(st_data);
    model_adv();
    st_wr = 0;
    rot++;
    st_port = rot[2];
    st_addr = rot & 3;
  endtask

  task automatic wr(input bit p, input int a, input int d);
    st_wr = 1; st_port = p; st_addr = a; st_data = d;
    tick();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dot_en = 0; reg_port = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state for every address on both ports
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 4; a++) begin
        reg_port = 1'(p); reg_addr = 2'(a);
        #1;
        chk(reg_rdata == 8'h00, "R11 reset read", reg_rdata, 0);
      end
    end
    chk({irq_vblank, irq_vmatch, hblank_dma} == 5'b0, "R11 reset pulses", 0, 0);
    @(negedge clk);
    rst_n = 1;
    // R5 R6: low byte all ones (bits 0..2 ignored), R10 separate copies
    wr(0, 0, 8'hFF);
    wr(0, 1, 8'h03);   // port 0 compare 0x103: never reached
    wr(1, 0, 8'h2F);   // port 1: vblank en + compare en, low bits ignored
    wr(1, 1, 8'h02);   // port 1 compare 2
    wr(0, 2, 8'h55);   // R6 line counter writes ignored
    wr(1, 3, 8'h01);
    run(4);
    dot_mode = 1;
    run(2 * TOT * LINE * 4 / 3 + 40);
    // port 0 compare line 6 (blank line), port 1 vblank off, compare 0 (wrap)
    wr(0, 0, 8'h20);
    wr(0, 1, 8'h06);
    wr(1, 0, 8'h20);
    wr(1, 1, 8'h00);
    dot_mode = 0;
    run(2 * TOT * LINE + 10);
    // R8: compare set to the current line mid-line leaves the flag until next change
    while (!(mv == 3 && mh == 5)) tick();
    wr(1, 1, 8'h03);
    wr(0, 0, 8'h08);   // port 0 vblank only
    run(2 * LINE);
    // R5 R6: clear enables, keep compare bit 8 through bit 7
    wr(1, 0, 8'h80);
    run(TOT * LINE + 20);
    dot_mode = 1;
    wr(0, 0, 8'h38);
    wr(0, 1, 8'h07);   // last line, outside vblank
    run(2 * TOT * LINE * 4 / 3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule